// File: doc/BRIEF.md
# Reservation Station Pool with Result-Bus Snooping

This block holds the waiting instructions for one kind of execution unit in an out-of-order floating-point core. An issue stage writes an opcode and two sources into a free slot. Each source comes in one of two forms. It can be a finished value, marked by a producer tag of zero. It can also be the nonzero tag of the station that will compute it. Each slot carries a fixed tag of its own, `BASE_TAG + index`, and no two slots in the core share a tag.

Every busy slot watches the shared result bus. When the tag on the bus matches a pending source tag, the slot copies the bus data and clears that tag. A slot becomes eligible once both of its tags are zero. Each cycle, a selector offers the eligible slot that was issued earliest to the execution unit. That slot stays occupied until its own tag appears on the result bus, and the slot is then released.

Top module: `rs_pool`

## Requirements
- R1: After a synchronous reset, every slot is free, `iss_ready` is 1 and `disp_valid` is 0.
- R2: An issue is accepted when `iss_valid` and `iss_ready` are both high at a clock edge. It goes into the lowest-index free slot. `iss_tag` shows that slot's tag, `BASE_TAG + index`. A source tag of 0 means the accompanying value is valid.
- R3: `iss_ready` is low whenever all slots are busy. An `iss_valid` that arrives while `iss_ready` is low has no effect.
- R4: A busy slot that waits on tag T takes `bus_data` into that source, and clears the source tag, at an edge where `bus_valid` is high and `bus_tag` equals T. A different tag on the bus changes nothing.
- R5: Suppose an issue is accepted in the same cycle that the bus broadcasts the tag named by one of its sources. The slot then stores the bus data for that source and stores a zero tag.
- R6: A slot may be offered only when both of its source tags are zero. It is offered in the cycle after its last source becomes present. `disp_op`, `disp_a`, `disp_b` and `disp_tag` carry the stored opcode, the first source, the second source and the slot's tag.
- R7: When several eligible slots compete, the one issued earliest is offered, whatever its index.
- R8: An offer taken with `disp_ready` high at an edge is never repeated for that slot.
- R9: A busy slot is released at an edge where `bus_valid` is high and `bus_tag` equals its own tag. From the next cycle on, it can be issued into again.
- R10: While `bus_valid` is low, `bus_tag` and `bus_data` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Opcode to store |
| iss_j_tag | input | TAG_W | Producer tag of first source, 0 = value present |
| iss_j_val | input | DATA_W | First source value |
| iss_k_tag | input | TAG_W | Producer tag of second source, 0 = value present |
| iss_k_val | input | DATA_W | Second source value |
| iss_ready | output | 1 | A slot is free |
| iss_tag | output | TAG_W | Tag of the slot the next issue takes |
| bus_valid | input | 1 | Result broadcast valid |
| bus_tag | input | TAG_W | Tag of the producing station |
| bus_data | input | DATA_W | Broadcast result |
| disp_valid | output | 1 | An eligible slot is offered |
| disp_ready | input | 1 | Execution unit takes the offer |
| disp_op | output | OP_W | Offered opcode |
| disp_a | output | DATA_W | Offered first source |
| disp_b | output | DATA_W | Offered second source |
| disp_tag | output | TAG_W | Tag of offered slot |

## Verification
The bench builds the block with its defaults: four slots, tags 1 to 4, 4-bit tags and 64-bit data. The pool is therefore small enough to fill completely, which exercises the stall. The bench then releases slot 0 and issues into it again. This leaves a younger slot at a lower index than an older one, so that oldest-first selection and lowest-index selection give different answers. Tags 8 to 15 stand for producers in other pools. The bench uses them to test matching and non-matching broadcasts, capture at issue and the wake-up of each source separately.

// File: rtl/rs_pool.sv
module rs_pool #(
  parameter int ENTRIES  = 4,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int OP_W     = 4,
  parameter int BASE_TAG = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [TAG_W-1:0]  iss_j_tag,
  input  logic [DATA_W-1:0] iss_j_val,
  input  logic [TAG_W-1:0]  iss_k_tag,
  input  logic [DATA_W-1:0] iss_k_val,
  output logic              iss_ready,
  output logic [TAG_W-1:0]  iss_tag,
  input  logic              bus_valid,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              disp_valid,
  input  logic              disp_ready,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag
);
  localparam int RANK_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W  = $clog2(ENTRIES + 1);

  function automatic logic [TAG_W-1:0] tag_of(input int idx);
    return TAG_W'(BASE_TAG + idx);
  endfunction

  logic [ENTRIES-1:0]             busy_q, sent_q;
  logic [ENTRIES-1:0][OP_W-1:0]   op_q;
  logic [ENTRIES-1:0][DATA_W-1:0] vj_q, vk_q;
  logic [ENTRIES-1:0][TAG_W-1:0]  qj_q, qk_q;
  logic [ENTRIES-1:0][RANK_W-1:0] rank_q, drop;

  logic [ENTRIES-1:0] rdy, freeing;
  logic [RANK_W-1:0]  slot, pick;
  logic               slot_found, pick_found;
  logic [CNT_W-1:0]   live_after;
  logic               issue_go, take;
  logic               j_hit, k_hit;

  always_comb begin
    slot = '0;
    slot_found = 1'b0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        slot = RANK_W'(i);
        slot_found = 1'b1;
      end
    end
  end

  assign iss_ready = slot_found;
  assign iss_tag   = tag_of(int'(slot));
  assign issue_go  = iss_valid & slot_found;
  assign j_hit     = bus_valid & (iss_j_tag != '0) & (bus_tag == iss_j_tag);
  assign k_hit     = bus_valid & (iss_k_tag != '0) & (bus_tag == iss_k_tag);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flags
    assign rdy[g]     = busy_q[g] & ~sent_q[g] & (qj_q[g] == '0) & (qk_q[g] == '0);
    assign freeing[g] = busy_q[g] & bus_valid & (bus_tag == tag_of(g));
  end

  always_comb begin
    pick = '0;
    pick_found = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (rdy[i] && (!pick_found || rank_q[i] < rank_q[pick])) begin
        pick = RANK_W'(i);
        pick_found = 1'b1;
      end
    end
  end

  assign disp_valid = pick_found;
  assign disp_op    = op_q[pick];
  assign disp_a     = vj_q[pick];
  assign disp_b     = vk_q[pick];
  assign disp_tag   = tag_of(int'(pick));
  assign take       = pick_found & disp_ready;

  always_comb begin
    live_after = '0;
    for (int i = 0; i < ENTRIES; i++)
      live_after = live_after + CNT_W'(busy_q[i] & ~freeing[i]);
  end

  always_comb begin
    for (int i = 0; i < ENTRIES; i++) begin
      drop[i] = '0;
      for (int j = 0; j < ENTRIES; j++)
        if (freeing[j] && rank_q[j] < rank_q[i])
          drop[i] = drop[i] + RANK_W'(1);
    end
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        busy_q[g] <= 1'b0;
        sent_q[g] <= 1'b0;
        rank_q[g] <= '0;
        op_q[g]   <= '0;
        vj_q[g]   <= '0;
        vk_q[g]   <= '0;
        qj_q[g]   <= '0;
        qk_q[g]   <= '0;
      end else if (issue_go && slot == RANK_W'(g)) begin
        busy_q[g] <= 1'b1;
        sent_q[g] <= 1'b0;
        rank_q[g] <= RANK_W'(live_after);
        op_q[g]   <= iss_op;
        vj_q[g]   <= j_hit ? bus_data : iss_j_val;
        qj_q[g]   <= j_hit ? '0 : iss_j_tag;
        vk_q[g]   <= k_hit ? bus_data : iss_k_val;
        qk_q[g]   <= k_hit ? '0 : iss_k_tag;
      end else if (freeing[g]) begin
        busy_q[g] <= 1'b0;
        sent_q[g] <= 1'b0;
      end else if (busy_q[g]) begin
        rank_q[g] <= rank_q[g] - drop[g];
        if (take && pick == RANK_W'(g))
          sent_q[g] <= 1'b1;
        if (bus_valid && qj_q[g] != '0 && bus_tag == qj_q[g]) begin
          vj_q[g] <= bus_data;
          qj_q[g] <= '0;
        end
        if (bus_valid && qk_q[g] != '0 && bus_tag == qk_q[g]) begin
          vk_q[g] <= bus_data;
          qk_q[g] <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/rs_pool_checks.sv
module rs_pool_checks #(
  parameter int ENTRIES  = 4,
  parameter int DATA_W   = 64,
  parameter int TAG_W    = 4,
  parameter int RANK_W   = 2,
  parameter int BASE_TAG = 1
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             iss_valid,
  input logic                             iss_ready,
  input logic [TAG_W-1:0]                 iss_tag,
  input logic [TAG_W-1:0]                 iss_j_tag,
  input logic                             bus_valid,
  input logic [TAG_W-1:0]                 bus_tag,
  input logic [DATA_W-1:0]                bus_data,
  input logic                             disp_valid,
  input logic [TAG_W-1:0]                 disp_tag,
  input logic [ENTRIES-1:0]               busy,
  input logic [ENTRIES-1:0]               sent,
  input logic [ENTRIES-1:0][TAG_W-1:0]    qj,
  input logic [ENTRIES-1:0][TAG_W-1:0]    qk,
  input logic [ENTRIES-1:0][DATA_W-1:0]   vj,
  input logic [ENTRIES-1:0][RANK_W-1:0]   rank
);
  p_stall_r3: assert property (@(posedge clk) disable iff (rst)
    !iss_ready |-> (&busy));

  for (genvar g = 0; g < ENTRIES; g++) begin : g_one
    localparam logic [TAG_W-1:0] OWN = TAG_W'(BASE_TAG + g);

    p_offer_ready_r6: assert property (@(posedge clk) disable iff (rst)
      (disp_valid && disp_tag == OWN) |-> (busy[g] && qj[g] == '0 && qk[g] == '0));

    p_release_r9: assert property (@(posedge clk) disable iff (rst)
      (busy[g] && bus_valid && bus_tag == OWN) |=> !busy[g]);

    p_capture_r4: assert property (@(posedge clk) disable iff (rst)
      (busy[g] && qj[g] != '0 && bus_valid && bus_tag == qj[g] && bus_tag != OWN)
      |=> (qj[g] == '0 && vj[g] == $past(bus_data)));

    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
      (iss_valid && iss_ready && iss_tag == OWN && iss_j_tag != '0 &&
       bus_valid && bus_tag == iss_j_tag)
      |=> (busy[g] && qj[g] == '0 && vj[g] == $past(bus_data)));

    for (genvar h = 0; h < ENTRIES; h++) begin : g_pair
      if (h != g) begin : g_ne
        p_oldest_r7: assert property (@(posedge clk) disable iff (rst)
          (disp_valid && disp_tag == OWN && busy[h] && !sent[h] &&
           qj[h] == '0 && qk[h] == '0) |-> (rank[g] < rank[h]));

        p_rank_unique_r7: assert property (@(posedge clk) disable iff (rst)
          (busy[g] && busy[h]) |-> (rank[g] != rank[h]));
      end
    end
  end
endmodule

bind rs_pool rs_pool_checks #(
  .ENTRIES(ENTRIES), .DATA_W(DATA_W), .TAG_W(TAG_W),
  .RANK_W(RANK_W), .BASE_TAG(BASE_TAG)
) u_checks (
  .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_tag(iss_tag), .iss_j_tag(iss_j_tag), .bus_valid(bus_valid),
  .bus_tag(bus_tag), .bus_data(bus_data), .disp_valid(disp_valid),
  .disp_tag(disp_tag), .busy(busy_q), .sent(sent_q), .qj(qj_q),
  .qk(qk_q), .vj(vj_q), .rank(rank_q)
);

// File: tb/rs_pool_test.sv
module rs_pool_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        iss_valid;
  logic [3:0]  iss_op, iss_j_tag, iss_k_tag;
  logic [63:0] iss_j_val, iss_k_val;
  logic        iss_ready;
  logic [3:0]  iss_tag;
  logic        bus_valid;
  logic [3:0]  bus_tag;
  logic [63:0] bus_data;
  logic        disp_valid, disp_ready;
  logic [3:0]  disp_op, disp_tag;
  logic [63:0] disp_a, disp_b;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  rs_pool uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_j_tag(iss_j_tag), .iss_j_val(iss_j_val), .iss_k_tag(iss_k_tag),
    .iss_k_val(iss_k_val), .iss_ready(iss_ready), .iss_tag(iss_tag),
    .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .disp_valid(disp_valid), .disp_ready(disp_ready), .disp_op(disp_op),
    .disp_a(disp_a), .disp_b(disp_b), .disp_tag(disp_tag)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_reset();
    rst = 1'b1; iss_valid = 1'b0; bus_valid = 1'b0; disp_ready = 1'b0;
    iss_op = '0; iss_j_tag = '0; iss_k_tag = '0; iss_j_val = '0; iss_k_val = '0;
    bus_tag = '0; bus_data = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [3:0] jt, input logic [63:0] jv,
                       input logic [3:0] kt, input logic [63:0] kv);
    iss_valid = 1'b1; iss_op = op;
    iss_j_tag = jt; iss_j_val = jv; iss_k_tag = kt; iss_k_val = kv;
    tick();
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic v, input logic [3:0] t, input logic [63:0] d);
    bus_valid = v; bus_tag = t; bus_data = d;
    tick();
    bus_valid = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 iss_ready", 64'(iss_ready), 64'd1);
    chk("R1 disp_valid", 64'(disp_valid), 64'd0);
    chk("R2 first tag", 64'(iss_tag), 64'd1);
  endtask

  task automatic t_ready_issue();
    do_reset();
    issue(4'd3, 4'd0, 64'hA5A5_0000_1111_2222, 4'd0, 64'h0123_4567_89AB_CDEF);
    chk("R6 offered", 64'(disp_valid), 64'd1);
    chk("R6 op", 64'(disp_op), 64'd3);
    chk("R6 a", disp_a, 64'hA5A5_0000_1111_2222);
    chk("R6 b", disp_b, 64'h0123_4567_89AB_CDEF);
    chk("R2 slot tag", 64'(disp_tag), 64'd1);
    chk("R2 next tag", 64'(iss_tag), 64'd2);
  endtask

  task automatic t_snoop();
    do_reset();
    issue(4'd5, 4'd8, 64'd0, 4'd0, 64'd77);
    chk("R6 waiting", 64'(disp_valid), 64'd0);
    bcast(1'b1, 4'd9, 64'hDEAD);
    chk("R4 other tag", 64'(disp_valid), 64'd0);
    bcast(1'b0, 4'd8, 64'hBEEF);
    chk("R10 bus idle", 64'(disp_valid), 64'd0);
    bcast(1'b1, 4'd8, 64'hCAFE_F00D);
    chk("R4 woke", 64'(disp_valid), 64'd1);
    chk("R4 captured", disp_a, 64'hCAFE_F00D);
    chk("R4 other kept", disp_b, 64'd77);
  endtask

  task automatic t_bypass();
    do_reset();
    bus_valid = 1'b1; bus_tag = 4'd9; bus_data = 64'h1234_5678;
    issue(4'd1, 4'd9, 64'd0, 4'd0, 64'd4);
    bus_valid = 1'b0;
    chk("R5 eligible", 64'(disp_valid), 64'd1);
    chk("R5 value", disp_a, 64'h1234_5678);
  endtask

  task automatic t_two_sources();
    do_reset();
    issue(4'd2, 4'd14, 64'd0, 4'd15, 64'd0);
    bcast(1'b1, 4'd15, 64'd222);
    chk("R6 one missing", 64'(disp_valid), 64'd0);
    bcast(1'b1, 4'd14, 64'd111);
    chk("R6 both in", 64'(disp_valid), 64'd1);
    chk("R4 first", disp_a, 64'd111);
    chk("R4 second", disp_b, 64'd222);
  endtask

  task automatic t_full_order();
    do_reset();
    for (int i = 0; i < 4; i++)
      issue(4'(i), 4'(10 + i), 64'd0, 4'd0, 64'(i));
    chk("R3 full", 64'(iss_ready), 64'd0);
    issue(4'd7, 4'd0, 64'd9, 4'd0, 64'd9);
    chk("R3 ignored", 64'(disp_valid), 64'd0);
    bcast(1'b1, 4'd1, 64'd0);
    chk("R9 freed", 64'(iss_ready), 64'd1);
    chk("R9 reuse tag", 64'(iss_tag), 64'd1);
    issue(4'd6, 4'd0, 64'd60, 4'd0, 64'd61);
    bcast(1'b1, 4'd12, 64'd50);
    chk("R7 oldest wins", 64'(disp_tag), 64'd3);
    chk("R7 oldest op", 64'(disp_op), 64'd2);
    disp_ready = 1'b1;
    tick();
    chk("R8 next offer", 64'(disp_tag), 64'd1);
    chk("R8 next op", 64'(disp_op), 64'd6);
    tick();
    disp_ready = 1'b0;
    chk("R8 none left", 64'(disp_valid), 64'd0);
    bcast(1'b1, 4'd3, 64'd0);
    chk("R9 release", 64'(iss_tag), 64'd3);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ready_issue();
    t_snoop();
    t_bypass();
    t_two_sources();
    t_full_order();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule